// File: doc/BRIEF.md
# Two-Wire Bus Slave for a Configuration Register

This block is a slave on a two-wire serial bus. It runs entirely in the system clock domain and oversamples the bus clock and data lines. It controls the data line only through a pull-low enable. When the enable is low, the line floats high through the external pull-up. Three strap inputs select which of eight possible slaves on the bus this instance answers to.

After a START, the first byte carries a fixed 4-bit device-type code, the three address bits and a direction bit. When the code and the address match, the slave acknowledges. On a write, every following byte is acknowledged. Once the acknowledge clock ends, the byte is handed to the configuration register as a single-cycle strobe. On a read, the slave returns the byte present on its readback input. It keeps returning that byte for as long as the master acknowledges.

Top module: `twi_cfg_slave`

## Requirements
- R1: After reset the pull-low enable and the write strobe are both low.
- R2: A control byte is acknowledged when bits 7:4 equal 0101, bits 3:1 equal the strap pins (bit 3 = strap[2]), and bit 0 gives the direction (1 = read, 0 = write). The slave acknowledges by pulling the data line low for the whole high phase of the ninth clock.
- R3: A control byte with a wrong code or a wrong address gets no acknowledge. The slave then neither pulls the line nor strobes until the next START.
- R4: On a write, each data byte is acknowledged. After the ninth clock falls, a one-cycle write strobe carries that byte. Any number of bytes may follow, and each one gives its own strobe, in bus order.
- R5: Bytes move most-significant bit first in both directions.
- R6: On a read, the slave sends the readback byte. When the master acknowledges it, the readback input is loaded again and sent as the next byte.
- R7: After a master NACK, the slave releases the data line, and the line stays high until the STOP.
- R8: A repeated START discards a partly received byte without a strobe and restarts the control-byte phase.
- R9: A STOP in the middle of a byte returns the slave to idle without a strobe.
- R10: Transfers work with bus clocks of 100 kHz and 400 kHz from a 50 MHz system clock. The system clock must be at least 16 times the bus clock.
- R11: The pull-low enable changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Address strap pins |
| sda_pull_o | output | 1 | When high, pulls the data line low |
| wr_stb_o | output | 1 | One-cycle strobe for a written byte |
| wr_data_o | output | 8 | Byte that goes with the write strobe |
| rd_data_i | input | 8 | Configuration byte returned on reads |

## Verification
A wrong bit count or a wrong sequencer state shows up at the pins within one bus clock. It appears as an acknowledge missing from the ninth clock, as a line pulled low in a slot that belongs to the master, or as a strobe carrying a shifted byte. A faulty address compare shows up as an acknowledge on the control byte of a foreign slave, or as no acknowledge on its own. A missed START or STOP leaves the slave out of step with the bus. The next transfer then shows this as a lost or spurious strobe.

// File: rtl/twi_pkg.sv
package twi_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_CTRL_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK
   } twi_state_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("twi_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s_i,
   input  logic sda_s_i,
   output logic scl_lvl_o,
   output logic sda_lvl_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s_i;
         sda_q <= sda_s_i;
      end
   end

   assign scl_lvl_o  = scl_s_i;
   assign sda_lvl_o  = sda_s_i;
   assign scl_rise_o = scl_s_i & ~scl_q;
   assign scl_fall_o = ~scl_s_i & scl_q;
   assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
   assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
   import twi_pkg::*;
#(
   parameter int              CODE_W   = 4,
   parameter int              ADDR_W   = 3,
   parameter logic [CODE_W-1:0] DEV_CODE = 4'b0101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              sda_lvl_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic [ADDR_W-1:0] strap_i,
   input  logic [BYTE_W-1:0] rd_data_i,
   output logic              pull_o,
   output logic              stb_o,
   output logic [BYTE_W-1:0] data_o,
   output logic              idle_o
);
   localparam int                CNT_W    = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(BYTE_W);

   twi_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] shreg_q;
   logic [BYTE_W-1:0] txreg_q;
   logic              rd_mode_q;
   logic              mack_q;
   logic              pull_q;
   logic              stb_q;
   logic [BYTE_W-1:0] data_q;
   logic              ctrl_hit;

   assign ctrl_hit = (shreg_q[BYTE_W-1 -: CODE_W] == DEV_CODE) &&
                     (shreg_q[ADDR_W:1] == strap_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         shreg_q   <= '0;
         txreg_q   <= '0;
         rd_mode_q <= 1'b0;
         mack_q    <= 1'b0;
         pull_q    <= 1'b0;
         stb_q     <= 1'b0;
         data_q    <= '0;
      end else begin
         stb_q <= 1'b0;
         if (start_i) begin
            state_q <= ST_CTRL;
            cnt_q   <= '0;
            pull_q  <= 1'b0;
         end else if (stop_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pull_q  <= 1'b0;
         end else begin
            case (state_q)
               ST_CTRL, ST_WR: begin
                  if (scl_rise_i) begin
                     shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
                     cnt_q   <= cnt_q + 1'b1;
                  end else if (scl_fall_i && cnt_q == CNT_FULL) begin
                     cnt_q <= '0;
                     if (state_q == ST_WR) begin
                        pull_q  <= 1'b1;
                        state_q <= ST_WR_ACK;
                     end else if (ctrl_hit) begin
                        pull_q    <= 1'b1;
                        rd_mode_q <= shreg_q[0];
                        state_q   <= ST_CTRL_ACK;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end
               end
               ST_CTRL_ACK: begin
                  if (scl_fall_i) begin
                     if (rd_mode_q) begin
                        txreg_q <= rd_data_i;
                        pull_q  <= ~rd_data_i[BYTE_W-1];
                        state_q <= ST_RD;
                     end else begin
                        pull_q  <= 1'b0;
                        state_q <= ST_WR;
                     end
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall_i) begin
                     pull_q  <= 1'b0;
                     stb_q   <= 1'b1;
                     data_q  <= shreg_q;
                     state_q <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_rise_i) begin
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall_i) begin
                     if (cnt_q == CNT_FULL) begin
                        pull_q  <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= ST_RD_ACK;
                     end else begin
                        pull_q  <= ~txreg_q[BYTE_W-2];
                        txreg_q <= txreg_q << 1;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise_i) begin
                     mack_q <= ~sda_lvl_i;
                  end else if (scl_fall_i) begin
                     if (mack_q) begin
                        txreg_q <= rd_data_i;
                        pull_q  <= ~rd_data_i[BYTE_W-1];
                        state_q <= ST_RD;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign pull_o = pull_q;
   assign stb_o  = stb_q;
   assign data_o = data_q;
   assign idle_o = (state_q == ST_IDLE);
endmodule

// File: rtl/twi_cfg_slave.sv
module twi_cfg_slave
   import twi_pkg::*;
#(
   parameter int                CODE_W      = 4,
   parameter int                ADDR_W      = 3,
   parameter logic [CODE_W-1:0] DEV_CODE    = 4'b0101,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] strap_i,
   output logic              sda_pull_o,
   output logic              wr_stb_o,
   output logic [BYTE_W-1:0] wr_data_o,
   input  logic [BYTE_W-1:0] rd_data_i
);
   generate
      if (CODE_W + ADDR_W + 1 != BYTE_W) begin : g_bad_ctrl_layout
         $error("control byte fields must fill exactly one byte");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic fsm_idle;

   twi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   ({scl_s, sda_s})
   );

   twi_bus_events events_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_s_i    (scl_s),
      .sda_s_i    (sda_s),
      .scl_lvl_o  (scl_lvl),
      .sda_lvl_o  (sda_lvl),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_det),
      .stop_o     (stop_det)
   );

   twi_slave_fsm #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise_i (scl_rise),
      .scl_fall_i (scl_fall),
      .sda_lvl_i  (sda_lvl),
      .start_i    (start_det),
      .stop_i     (stop_det),
      .strap_i    (strap_i),
      .rd_data_i  (rd_data_i),
      .pull_o     (sda_pull_o),
      .stb_o      (wr_stb_o),
      .data_o     (wr_data_o),
      .idle_o     (fsm_idle)
   );
endmodule

// File: rtl/twi_cfg_slave_chk.sv
module twi_cfg_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_lvl,
   input logic pull,
   input logic stb,
   input logic idle
);
   assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pull) |-> !scl_lvl);

   assert_stb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stb |=> !stb);

   assert_stb_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stb |-> ($past(pull) && !pull));

   assert_stb_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stb |-> !scl_lvl);

   assert_idle_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !pull);

   assert_idle_no_stb_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(idle) && idle) |-> !stb);
endmodule

bind twi_cfg_slave twi_cfg_slave_chk chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_lvl (scl_lvl),
   .pull    (sda_pull_o),
   .stb     (wr_stb_o),
   .idle    (fsm_idle)
);

// File: tb/twi_cfg_slave_tb.sv
module twi_cfg_slave_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] strap = 3'b101;
   logic [7:0] rd_byte = 8'h00;
   logic       sda_pull;
   logic       wr_stb;
   logic [7:0] wr_data;
   wire        sda_line = sda_m & ~sda_pull;

   int tests = 0;
   int fails = 0;
   int q_cyc = 31;
   int stb_cnt = 0;
   logic [7:0] stb_log [0:63];
   int pull_cycles = 0;
   int edge_viol = 0;
   logic prev_pull = 1'b0;

   localparam logic [7:0] CTRL_WR   = 8'h5A;
   localparam logic [7:0] CTRL_RD   = 8'h5B;
   localparam logic [7:0] BAD_CODE  = 8'h6A;
   localparam logic [7:0] BAD_ADDR  = 8'h56;

   always #10 clk = ~clk;

   twi_cfg_slave dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_line),
      .strap_i    (strap),
      .sda_pull_o (sda_pull),
      .wr_stb_o   (wr_stb),
      .wr_data_o  (wr_data),
      .rd_data_i  (rd_byte)
   );

   always @(negedge clk) begin
      if (wr_stb) begin
         stb_log[stb_cnt % 64] = wr_data;
         stb_cnt = stb_cnt + 1;
      end
      if (sda_pull) pull_cycles = pull_cycles + 1;
      if (rst_n && sda_pull != prev_pull && scl_m) edge_viol = edge_viol + 1;
      prev_pull = sda_pull;
   end

   task automatic check_eq(input string tag, input int act, input int exp);
      tests = tests + 1;
      if (act != exp) begin
         fails = fails + 1;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_q();
      repeat (q_cyc) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_q();
      scl_m = 1'b1; wait_q();
      sda_m = 1'b0; wait_q();
      scl_m = 1'b0; wait_q();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_q();
      scl_m = 1'b1; wait_q();
      sda_m = 1'b1; wait_q();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wait_q();
      scl_m = 1'b1; wait_q(); wait_q();
      scl_m = 1'b0; wait_q();
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; wait_q();
      scl_m = 1'b1; wait_q();
      b = sda_line; wait_q();
      scl_m = 1'b0; wait_q();
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      recv_bit(ack);
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic master_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         v[i] = b;
      end
      send_bit(master_ack ? 1'b0 : 1'b1);
   endtask

   task automatic t_reset();
      check_eq("R1 pull after reset", sda_pull, 0);
      check_eq("R1 strobe after reset", wr_stb, 0);
   endtask

   task automatic t_write_one(input logic [7:0] v, input string tag);
      logic ack;
      int base = stb_cnt;
      bus_start();
      send_byte(CTRL_WR, ack);
      check_eq({tag, " R2 control ack"}, ack, 0);
      send_byte(v, ack);
      check_eq({tag, " R4 data ack"}, ack, 0);
      bus_stop();
      check_eq({tag, " R4 strobe count"}, stb_cnt - base, 1);
      check_eq({tag, " R5 byte value"}, stb_log[base % 64], v);
   endtask

   task automatic t_write_multi();
      logic ack;
      logic [7:0] vals [3] = '{8'h3C, 8'hC3, 8'h01};
      int base = stb_cnt;
      bus_start();
      send_byte(CTRL_WR, ack);
      foreach (vals[i]) begin
         send_byte(vals[i], ack);
         check_eq("R4 multi data ack", ack, 0);
      end
      bus_stop();
      check_eq("R4 multi strobe count", stb_cnt - base, 3);
      foreach (vals[i]) check_eq("R4 multi order", stb_log[(base + i) % 64], vals[i]);
   endtask

   task automatic t_foreign(input logic [7:0] ctrl, input string tag);
      logic ack;
      int base = stb_cnt;
      int pbase = pull_cycles;
      bus_start();
      send_byte(ctrl, ack);
      check_eq({tag, " R3 no control ack"}, ack, 1);
      send_byte(8'h00, ack);
      check_eq({tag, " R3 no data ack"}, ack, 1);
      bus_stop();
      check_eq({tag, " R3 no strobe"}, stb_cnt - base, 0);
      check_eq({tag, " R3 never pulled"}, pull_cycles - pbase, 0);
   endtask

   task automatic t_read(input logic [7:0] v, input string tag);
      logic ack, b;
      logic [7:0] got;
      int pbase;
      rd_byte = v;
      bus_start();
      send_byte(CTRL_RD, ack);
      check_eq({tag, " R2 read control ack"}, ack, 0);
      recv_byte(got, 1'b1);
      check_eq({tag, " R6 R5 first byte"}, got, v);
      recv_byte(got, 1'b0);
      check_eq({tag, " R6 repeated byte"}, got, v);
      pbase = pull_cycles;
      recv_bit(b);
      check_eq({tag, " R7 line high after nack"}, b, 1);
      bus_stop();
      check_eq({tag, " R7 no pull after nack"}, pull_cycles - pbase, 0);
   endtask

   task automatic t_rep_start();
      logic ack;
      int base = stb_cnt;
      bus_start();
      send_byte(CTRL_WR, ack);
      for (int i = 0; i < 4; i++) send_bit(1'b1);
      bus_start();
      send_byte(CTRL_WR, ack);
      check_eq("R8 control ack after restart", ack, 0);
      send_byte(8'h55, ack);
      bus_stop();
      check_eq("R8 single strobe", stb_cnt - base, 1);
      check_eq("R8 byte after restart", stb_log[base % 64], 8'h55);
   endtask

   task automatic t_stop_mid();
      logic ack;
      int base = stb_cnt;
      bus_start();
      send_byte(CTRL_WR, ack);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      bus_stop();
      check_eq("R9 no strobe on early stop", stb_cnt - base, 0);
      t_write_one(8'h96, "R9 follow-up");
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_write_one(8'hA5, "R4 single");
      t_write_multi();
      t_foreign(BAD_CODE, "code");
      t_foreign(BAD_ADDR, "addr");
      t_read(8'h9B, "fast");
      t_rep_start();
      t_stop_mid();
      q_cyc = 125;
      t_write_one(8'h7E, "R10 slow");
      t_read(8'h62, "R10 slow");
      check_eq("R11 pull changed while clock high", edge_viol, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule